// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Combiner

This block holds the six status flags of an SPI peripheral and merges them into one interrupt request. Datapath logic sends one-cycle event pulses: transmit holding stage drained, receive word landed, configuration fault, receive overrun, and frame-format error. It also sends the locally computed receive CRC together with the CRC word taken off the wire. The register file sends access strobes that say whether a register is read or written, which register is selected and, for status writes, the write data. The flags come out in their status-register positions, and a single interrupt line is driven from them through three enable inputs.

Each flag has its own way to be cleared. The transmit and receive flags clear on a data-register write and a data-register read. The CRC and format flags clear when a status write puts 0 in their bit. The configuration-fault and overrun flags need an ordered pair of accesses. The first access of a pair arms a one-bit tracker, and any unrelated access in between cancels it. Idle cycles between the two steps are allowed. When a set event and a clearing access fall in the same cycle, the flag stays set.

Top module: `spi_flag_irq`

## Requirements
- R1: After reset the flags read 6'b000010: only the transmit-empty flag is 1, both two-step trackers are disarmed, and the interrupt is 0 while all enables are 0.
- R2: Status bit positions are 0 receive-not-empty, 1 transmit-empty, 2 CRC error, 3 configuration fault, 4 receive overrun, 5 format error. `bus_sel` codes are 0 control-0, 1 control-1, 2 status, 3 data. Each event pulse sets its flag, visible one clock later.
- R3: A write with `bus_sel`=3 clears transmit-empty on the next clock.
- R4: A read with `bus_sel`=3 clears receive-not-empty on the next clock.
- R5: Configuration fault clears on a control-0 write only if the access just before it was a status read or write. Idle cycles between the two are allowed. Any other access between them, or a control-0 write alone, leaves the flag set.
- R6: Receive overrun clears on a status read only if the access just before it was a data read. Idle cycles between the two are allowed. The reverse order, or any other access between them, leaves the flag set.
- R7: A status write with 0 in bit 2 clears CRC error, and a status write with 0 in bit 5 clears format error. Writing 1 to either bit leaves that flag unchanged.
- R8: When `crc_chk_en` is 1 and `crc_word_vld` pulses, CRC error is set if `crc_calc` differs from `crc_recv`. A match, or checking disabled, leaves the flag unchanged.
- R9: If a flag's set event and its completing clear access fall in the same cycle, the flag is 1 afterwards.
- R10: `irq` is 1 exactly when transmit-empty and `ie_tx` are both 1, or receive-not-empty and `ie_rx` are both 1, or any of the four error flags and `ie_err` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select (0 ctl0, 1 ctl1, 2 status, 3 data) |
| bus_wdata | input | 6 | Status write data in flag bit positions |
| ev_tx_empty | input | 1 | Transmit holding stage drained |
| ev_rx_full | input | 1 | Received word available |
| ev_cfg_fault | input | 1 | Configuration fault detected |
| ev_rx_overrun | input | 1 | Receive overrun detected |
| ev_frame_err | input | 1 | Frame-format error detected |
| crc_chk_en | input | 1 | CRC checking enabled |
| crc_word_vld | input | 1 | Received CRC word present this cycle |
| crc_calc | input | CRC_W | Locally computed receive CRC |
| crc_recv | input | CRC_W | CRC word received from the line |
| ie_tx | input | 1 | Transmit interrupt enable |
| ie_rx | input | 1 | Receive interrupt enable |
| ie_err | input | 1 | Shared error interrupt enable |
| stat_flags | output | 6 | Flag bits in status positions |
| irq | output | 1 | Combined interrupt request |

## Verification
A set event and the clear of the same flag can fall in the same cycle. The bench provokes this on purpose: it arms the configuration-fault tracker and then pulses the fault together with the control-0 write. It does the same with a transmit-empty event and a data write, and with a CRC mismatch and a status write of 0. In every such cycle the flag must read 1 on the next clock. The reference model is compared on every cycle, so each of these collisions is judged against a prediction made independently of the design.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int NFLAG  = 6;
  localparam int F_RBNE = 0;
  localparam int F_TBE  = 1;
  localparam int F_CRC  = 2;
  localparam int F_CONF = 3;
  localparam int F_ORR  = 4;
  localparam int F_FMT  = 5;

  localparam logic [1:0] SEL_CTL0 = 2'd0;
  localparam logic [1:0] SEL_CTL1 = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  // flags that clear by writing 0 to their status bit
  localparam logic [NFLAG-1:0] W0C_MASK = (NFLAG'(1) << F_CRC) | (NFLAG'(1) << F_FMT);
  localparam logic [NFLAG-1:0] ERR_MASK = (NFLAG'(1) << F_CRC) | (NFLAG'(1) << F_CONF)
                                        | (NFLAG'(1) << F_ORR) | (NFLAG'(1) << F_FMT);

  function automatic logic irq_merge(input logic [NFLAG-1:0] f,
                                     input logic ie_t, input logic ie_r, input logic ie_e);
    return (f[F_TBE] & ie_t) | (f[F_RBNE] & ie_r) | ((|(f & ERR_MASK)) & ie_e);
  endfunction
endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/spi_seq_arm.sv
module spi_seq_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic first_i,
  input  logic second_i,
  output logic fire_o
);
  logic armed_q;

  assign fire_o = armed_q & second_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (first_i) armed_q <= 1'b1;
    else if (acc_i)   armed_q <= 1'b0;
  end
endmodule

// File: rtl/spi_crc_cmp.sv
module spi_crc_cmp #(
  parameter int CRC_W = 16
) (
  input  logic             chk_en,
  input  logic             word_vld,
  input  logic [CRC_W-1:0] calc,
  input  logic [CRC_W-1:0] recv,
  output logic             mismatch
);
  function automatic logic crc_differs(input logic [CRC_W-1:0] a, input logic [CRC_W-1:0] b);
    return |(a ^ b);
  endfunction

  assign mismatch = chk_en & word_vld & crc_differs(calc, recv);
endmodule

// File: rtl/spi_flag_irq.sv
module spi_flag_irq
  import spi_flag_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [1:0]       bus_sel,
  input  logic [5:0]       bus_wdata,
  input  logic             ev_tx_empty,
  input  logic             ev_rx_full,
  input  logic             ev_cfg_fault,
  input  logic             ev_rx_overrun,
  input  logic             ev_frame_err,
  input  logic             crc_chk_en,
  input  logic             crc_word_vld,
  input  logic [CRC_W-1:0] crc_calc,
  input  logic [CRC_W-1:0] crc_recv,
  input  logic             ie_tx,
  input  logic             ie_rx,
  input  logic             ie_err,
  output logic [5:0]       stat_flags,
  output logic             irq
);
  // decoded access events
  logic acc_any, stat_acc, stat_rd, stat_wr, ctl0_wr, data_rd, data_wr;
  assign acc_any  = bus_rd | bus_wr;
  assign stat_rd  = bus_rd & (bus_sel == SEL_STAT);
  assign stat_wr  = bus_wr & (bus_sel == SEL_STAT);
  assign stat_acc = stat_rd | stat_wr;
  assign ctl0_wr  = bus_wr & (bus_sel == SEL_CTL0);
  assign data_rd  = bus_rd & (bus_sel == SEL_DATA);
  assign data_wr  = bus_wr & (bus_sel == SEL_DATA);

  logic conf_fire, orr_fire, crc_mismatch;

  spi_seq_arm u_conf_seq (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_any),
    .first_i(stat_acc), .second_i(ctl0_wr), .fire_o(conf_fire)
  );

  spi_seq_arm u_orr_seq (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_any),
    .first_i(data_rd), .second_i(stat_rd), .fire_o(orr_fire)
  );

  spi_crc_cmp #(.CRC_W(CRC_W)) u_crc (
    .chk_en(crc_chk_en), .word_vld(crc_word_vld),
    .calc(crc_calc), .recv(crc_recv), .mismatch(crc_mismatch)
  );

  logic [NFLAG-1:0] set_vec, clr_vec, w0c_clr, seq_clr;

  always_comb begin
    set_vec         = '0;
    set_vec[F_RBNE] = ev_rx_full;
    set_vec[F_TBE]  = ev_tx_empty;
    set_vec[F_CRC]  = crc_mismatch;
    set_vec[F_CONF] = ev_cfg_fault;
    set_vec[F_ORR]  = ev_rx_overrun;
    set_vec[F_FMT]  = ev_frame_err;
  end

  always_comb begin
    seq_clr         = '0;
    seq_clr[F_RBNE] = data_rd;
    seq_clr[F_TBE]  = data_wr;
    seq_clr[F_CONF] = conf_fire;
    seq_clr[F_ORR]  = orr_fire;
  end

  assign w0c_clr = stat_wr ? (~bus_wdata & W0C_MASK) : '0;
  assign clr_vec = seq_clr | w0c_clr;

  logic [NFLAG-1:0] flag_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_cell
    spi_flag_cell #(.RST_VAL(i == F_TBE)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_vec[i]), .clr_i(clr_vec[i]), .q_o(flag_q[i])
    );
  end

  assign stat_flags = flag_q;
  assign irq        = irq_merge(flag_q, ie_tx, ie_rx, ie_err);
endmodule

// File: rtl/spi_flag_irq_chk.sv
module spi_flag_irq_chk
  import spi_flag_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic [1:0] bus_sel,
  input logic [5:0] bus_wdata,
  input logic       ev_tx_empty,
  input logic       ev_rx_full,
  input logic       ev_cfg_fault,
  input logic       ev_rx_overrun,
  input logic       crc_mismatch,
  input logic       conf_fire,
  input logic       orr_fire,
  input logic       ie_tx,
  input logic       ie_rx,
  input logic       ie_err,
  input logic [5:0] stat_flags,
  input logic       irq
);
  a_r3_tbe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_DATA && !ev_tx_empty) |=> !stat_flags[F_TBE]);

  a_r4_rbne_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == SEL_DATA && !ev_rx_full) |=> !stat_flags[F_RBNE]);

  a_r5_conf_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (conf_fire && !ev_cfg_fault) |=> !stat_flags[F_CONF]);

  a_r5_conf_falls_on_ctl0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_flags[F_CONF]) |-> $past(bus_wr && bus_sel == SEL_CTL0));

  a_r6_orr_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == SEL_STAT && $past(bus_rd && bus_sel == SEL_DATA) && !ev_rx_overrun)
      |=> !stat_flags[F_ORR]);

  a_r6_orr_falls_on_stat_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_flags[F_ORR]) |-> $past(orr_fire));

  a_r7_w1_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_STAT && bus_wdata[F_FMT]) |=> $stable(stat_flags[F_FMT]));

  a_r8_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    crc_mismatch |=> stat_flags[F_CRC]);

  a_r9_set_wins_conf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cfg_fault |=> stat_flags[F_CONF]);

  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_tx && !ie_rx && !ie_err) |-> !irq);

  a_r10_tx_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flags[F_TBE] && ie_tx) |-> irq);
endmodule

bind spi_flag_irq spi_flag_irq_chk u_chk (.*);

// File: tb/sim_spi_flag_irq.sv
module sim_spi_flag_irq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [1:0] bus_sel = 0;
  logic [5:0] bus_wdata = 0;
  logic ev_tx_empty = 0, ev_rx_full = 0, ev_cfg_fault = 0, ev_rx_overrun = 0, ev_frame_err = 0;
  logic crc_chk_en = 0, crc_word_vld = 0;
  logic [CW-1:0] crc_calc = 0, crc_recv = 0;
  logic ie_tx = 0, ie_rx = 0, ie_err = 0;
  logic [5:0] stat_flags;
  logic irq;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flag_irq #(.CRC_W(CW)) u0 (.*);

  // reference model state
  bit m_flag[6];
  bit m_conf_pending, m_orr_pending;
  bit model_on = 0;
  string tag_of[6] = '{"R4", "R3", "R7", "R5", "R6", "R7"};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit conf_done, orr_done;
    bit touched = bus_rd || bus_wr;
    conf_done = 0; orr_done = 0;
    case (bus_sel)
      2'd0: if (bus_wr && m_conf_pending) conf_done = 1;
      2'd2: if (bus_rd && m_orr_pending) orr_done = 1;
      default: ;
    endcase
    // clears first, sets afterwards so a set overrides
    if (bus_sel == 3 && bus_wr) m_flag[1] = 0;
    if (bus_sel == 3 && bus_rd) m_flag[0] = 0;
    if (conf_done) m_flag[3] = 0;
    if (orr_done) m_flag[4] = 0;
    if (bus_sel == 2 && bus_wr) begin
      if (bus_wdata[2] == 0) m_flag[2] = 0;
      if (bus_wdata[5] == 0) m_flag[5] = 0;
    end
    if (ev_rx_full) m_flag[0] = 1;
    if (ev_tx_empty) m_flag[1] = 1;
    if (crc_chk_en && crc_word_vld && crc_calc != crc_recv) m_flag[2] = 1;
    if (ev_cfg_fault) m_flag[3] = 1;
    if (ev_rx_overrun) m_flag[4] = 1;
    if (ev_frame_err) m_flag[5] = 1;
    if (touched) begin
      m_conf_pending = (bus_sel == 2);
      m_orr_pending  = (bus_sel == 3) && bus_rd;
    end
  endtask

  function automatic int model_irq();
    int e = m_flag[2] + m_flag[3] + m_flag[4] + m_flag[5];
    return ((m_flag[1] && ie_tx) || (m_flag[0] && ie_rx) || (e > 0 && ie_err)) ? 1 : 0;
  endfunction

  task automatic compare_all();
    for (int i = 0; i < 6; i++) check(tag_of[i], stat_flags[i], m_flag[i]);
    check("R10", irq, model_irq());
  endtask

  always @(posedge clk) if (model_on) model_step();

  task automatic tick();
    @(negedge clk);
    compare_all();
    bus_rd = 0; bus_wr = 0; bus_sel = 0; bus_wdata = 0;
    ev_tx_empty = 0; ev_rx_full = 0; ev_cfg_fault = 0; ev_rx_overrun = 0; ev_frame_err = 0;
    crc_word_vld = 0;
  endtask

  task automatic rd(input logic [1:0] s); bus_rd = 1; bus_sel = s; tick(); endtask
  task automatic wr(input logic [1:0] s, input logic [5:0] d);
    bus_wr = 1; bus_sel = s; bus_wdata = d; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_flag = '{0, 1, 0, 0, 0, 0};
    m_conf_pending = 0; m_orr_pending = 0;
    model_on = 1;
    // R1 reset state
    check("R1", stat_flags, 6'b000010);
    check("R1", irq, 0);
    tick();
    ie_tx = 1; #1 check("R10", irq, 1); ie_tx = 0;

    // R3 / R2 transmit-empty
    wr(3, 0); check("R3", stat_flags[1], 0);
    ev_tx_empty = 1; tick(); check("R2", stat_flags[1], 1);
    // R4 receive-not-empty
    ev_rx_full = 1; tick(); check("R2", stat_flags[0], 1);
    rd(3); check("R4", stat_flags[0], 0);

    // R5 configuration fault sequences
    ev_cfg_fault = 1; tick(); check("R2", stat_flags[3], 1);
    wr(0, 0); check("R5 ctl0 alone", stat_flags[3], 1);
    rd(2); wr(1, 0); wr(0, 0); check("R5 interposed", stat_flags[3], 1);
    rd(2); tick(); tick(); wr(0, 0); check("R5 stat rd seq", stat_flags[3], 0);
    ev_cfg_fault = 1; tick();
    wr(2, 6'h3f); wr(0, 0); check("R5 stat wr seq", stat_flags[3], 0);

    // R6 overrun sequences
    ev_rx_overrun = 1; tick(); check("R2", stat_flags[4], 1);
    rd(2); check("R6 reverse a", stat_flags[4], 1);
    rd(3); check("R6 reverse b", stat_flags[4], 1);
    wr(0, 0); rd(2); check("R6 interposed", stat_flags[4], 1);
    rd(3); tick(); rd(2); check("R6 good seq", stat_flags[4], 0);

    // R7 write-zero clears
    ev_frame_err = 1; crc_chk_en = 1; crc_word_vld = 1; crc_calc = 16'h1234; crc_recv = 16'h1235;
    tick(); check("R2", stat_flags[5], 1); check("R8 mismatch", stat_flags[2], 1);
    wr(2, 6'h3f); check("R7 w1 crc", stat_flags[2], 1); check("R7 w1 fmt", stat_flags[5], 1);
    wr(2, 6'b100000); check("R7 w0 crc", stat_flags[2], 0); check("R7 keep fmt", stat_flags[5], 1);
    wr(2, 6'b000000); check("R7 w0 fmt", stat_flags[5], 0);

    // R8 compare conditions
    crc_word_vld = 1; crc_recv = 16'h1234; tick(); check("R8 match", stat_flags[2], 0);
    crc_chk_en = 0; crc_word_vld = 1; crc_recv = 16'hbeef; tick(); check("R8 disabled", stat_flags[2], 0);
    crc_chk_en = 1; crc_word_vld = 0; tick(); check("R8 no word", stat_flags[2], 0);

    // R9 set beats clear
    ev_cfg_fault = 1; tick();
    rd(2); ev_cfg_fault = 1; wr(0, 0); check("R9 conf", stat_flags[3], 1);
    rd(2); wr(0, 0); check("R5 after R9", stat_flags[3], 0);
    ev_tx_empty = 1; wr(3, 0); check("R9 tbe", stat_flags[1], 1);
    crc_word_vld = 1; crc_recv = 16'h0; wr(2, 0); check("R9 crc", stat_flags[2], 1);
    wr(2, 0); check("R7", stat_flags[2], 0);

    // R10 masking, one enable at a time
    ev_rx_overrun = 1; ev_rx_full = 1; tick();
    wr(3, 0);
    ie_err = 0; ie_rx = 0; ie_tx = 0; #1 check("R10 none", irq, 0);
    ie_rx = 1; #1 check("R10 rx", irq, 1); ie_rx = 0;
    ie_err = 1; #1 check("R10 err", irq, 1);
    rd(3); tick(); rd(2); check("R10 err gone", irq, 0);
    ie_err = 0; ie_tx = 1; tick(); check("R10 tx off", irq, 0);
    ev_tx_empty = 1; tick(); check("R10 tx on", irq, 1);

    repeat (4) tick();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule